// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a port of input pins and raises one interrupt line when any pin meets the condition chosen for it. Each pin has its own configuration word holding a 4-bit sense code. The code selects a logic-low level, a logic-high level, a rising edge, a falling edge, either edge, or no detection at all. The pin inputs pass through a synchronizer before detection. Edges are found by comparing the synchronized value with the value it had one clock earlier.

Each detected event sets that pin's bit in a shared sticky flag register. Software reads the flag register, services each set bit and clears it by writing a one to it. The interrupt line is high whenever any flag is set. A level-sensed pin keeps setting its flag for as long as the level is held. Clearing such a flag therefore has no effect until the pin leaves the active level.

Access goes through a plain register port: a write strobe with an address and write data, and read data that follows the address combinationally.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every sense code is 0, every flag is 0 and `irq_o` is 0.
- R2: The configuration word of pin n is at byte address 4*n. Its sense code is held in bits 19:16, is written from the same bits and reads back as written. All other bits of the word read as 0.
- R3: With code 0x9 (rising), a flag sets when the synchronized pin goes 0 to 1 and not when it goes 1 to 0. The flag can be read on the third clock edge after the pin changes: two synchronizer stages, then the flag register.
- R4: With code 0xA (falling), a flag sets on a 1 to 0 change and not on a 0 to 1 change.
- R5: With code 0xB (either edge), a flag sets on every change of the synchronized pin.
- R6: With code 0x8 (low level), the flag sets on every clock while the pin is low. A clear written while the pin stays low leaves the flag set.
- R7: With code 0xC (high level), the flag sets on every clock while the pin is high. A clear written while the pin stays high leaves the flag set.
- R8: Code 0x0 disables detection. Every code not named in R3 to R7 also behaves as disabled. Writing 0 to a level-sensed pin's word stops the flag from setting again.
- R9: The flag register is at byte address 0xA0, with bit n for pin n. Writing 1 to a bit clears it and writing 0 leaves it unchanged. Writing all ones clears every flag. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R10: `irq_o` is 1 exactly when at least one flag is set.
- R11: Writes to any address that is neither a configuration word nor the flag register change no state, and such addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | NPINS (32) | Asynchronous pin inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt, OR of all flags |

## Verification
The bench writes a clear in exactly the cycle in which an either-edge event reaches the flag register. A design that gives the clear priority would lose that interrupt and read the bit back as 0. It clears level-sensed flags while the level is held and expects them to stay set. A design that latches level events only once would wrongly let them fall. It also checks that each edge mode ignores the opposite edge, that unlisted codes and unmapped or misaligned addresses have no effect, and that zero bits in a clear leave other flags alone. A decoder that is too loose, or a clear that writes the whole register, shows up as lost or changed flags.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int MODE_W        = 4;
  localparam int MODE_LSB      = 16;
  localparam logic [7:0] FLAG_OFS = 8'hA0;

  typedef enum logic [MODE_W-1:0] {
    SENSE_OFF    = 4'h0,
    SENSE_LVL_LO = 4'h8,
    SENSE_RISE   = 4'h9,
    SENSE_FALL   = 4'hA,
    SENSE_BOTH   = 4'hB,
    SENSE_LVL_HI = 4'hC
  } sense_e;

  // Event for one pin from its sense code, current and previous sample.
  function automatic logic sense_hit(logic [MODE_W-1:0] code, logic cur, logic prv);
    logic hit;
    case (code)
      SENSE_LVL_LO: hit = ~cur;
      SENSE_RISE:   hit = cur & ~prv;
      SENSE_FALL:   hit = ~cur & prv;
      SENSE_BOTH:   hit = cur ^ prv;
      SENSE_LVL_HI: hit = cur;
      default:      hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic sense_is_edge(logic [MODE_W-1:0] code);
    return (code == SENSE_RISE) || (code == SENSE_FALL) || (code == SENSE_BOTH);
  endfunction

  function automatic logic sense_is_level(logic [MODE_W-1:0] code);
    return (code == SENSE_LVL_LO) || (code == SENSE_LVL_HI);
  endfunction

endpackage

// File: rtl/pid_rst_sync.sv
module pid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pid_sync.sv
module pid_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);

  logic [STAGES-1:0][NPINS-1:0] stage_q;
  logic [STAGES-1:0][NPINS-1:0] stage_d;
  logic [NPINS-1:0]             prev_q;
  logic [NPINS-1:0]             prev_d;

  always_comb begin
    stage_d[0] = pins_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
    prev_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= prev_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/pid_pin_cell.sv
module pid_pin_cell
  import pid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_code,
  input  logic              cur,
  input  logic              prv,
  output logic [MODE_W-1:0] code_o,
  output logic              hit_o
);

  logic [MODE_W-1:0] code_q;
  logic [MODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (cfg_we) begin
      code_d = cfg_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= SENSE_OFF;
    end else begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign hit_o  = sense_hit(code_q, cur, prv);

endmodule

// File: rtl/pid_flags.sv
module pid_flags #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flags_o
);

  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] flag_d;

  // Event wins over a clear landing in the same cycle.
  always_comb begin
    flag_d = (flag_q & ~clr_i) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FLAG_OFS);

  logic                          srst_n;
  logic [NPINS-1:0]              pin_sync;
  logic [NPINS-1:0]              pin_prev;
  logic [NPINS-1:0]              pin_hit;
  logic [NPINS-1:0]              cfg_sel;
  logic [NPINS-1:0][MODE_W-1:0]  code_q;
  logic [NPINS-1:0]              clr_mask;
  logic [NPINS-1:0]              flag_q;
  logic                          flag_sel;

  pid_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pid_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (srst_n),
    .pins_i (pins_i),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  // Address decode
  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      cfg_sel[n] = (bus_addr == ADDR_W'(n * 4));
    end
    flag_sel = (bus_addr == FLAG_ADDR);
    clr_mask = (bus_we && flag_sel) ? bus_wdata[NPINS-1:0] : '0;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pid_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (srst_n),
      .cfg_we   (bus_we && cfg_sel[g]),
      .cfg_code (bus_wdata[MODE_LSB +: MODE_W]),
      .cur      (pin_sync[g]),
      .prv      (pin_prev[g]),
      .code_o   (code_q[g]),
      .hit_o    (pin_hit[g])
    );
  end

  pid_flags #(.NPINS(NPINS)) u_flags (
    .clk     (clk),
    .rst_n   (srst_n),
    .hit_i   (pin_hit),
    .clr_i   (clr_mask),
    .flags_o (flag_q)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (flag_sel) begin
      bus_rdata[NPINS-1:0] = flag_q;
    end
    for (int n = 0; n < NPINS; n++) begin
      if (cfg_sel[n]) begin
        bus_rdata[MODE_LSB +: MODE_W] = code_q[n];
      end
    end
  end

  assign irq_o = |flag_q;

endmodule

// File: rtl/pid_chk.sv
module pid_chk
  import pid_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                         clk,
  input logic                         srst_n,
  input logic [NPINS-1:0][MODE_W-1:0] code,
  input logic [NPINS-1:0]             sync,
  input logic [NPINS-1:0]             prev,
  input logic [NPINS-1:0]             hit,
  input logic [NPINS-1:0]             clr,
  input logic [NPINS-1:0]             flags,
  input logic                         irq,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            rdata
);

  logic [NPINS-1:0] edge_mask;
  logic [NPINS-1:0] lvl_mask;
  logic [NPINS-1:0] lvl_expect;

  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      edge_mask[n]  = sense_is_edge(code[n]);
      lvl_mask[n]   = sense_is_level(code[n]);
      lvl_expect[n] = (code[n] == SENSE_LVL_HI) ? sync[n] : ~sync[n];
    end
  end

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((flags & $past(hit)) == $past(hit)));  // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (($past(flags) & ~$past(clr) & ~flags) == '0));  // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!srst_n)
    ((flags & $past(clr) & ~$past(hit)) == '0));  // R9

  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!srst_n)
    ((~$past(flags) & flags & ~$past(edge_mask | lvl_mask)) == '0));  // R8

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!srst_n)
    ((hit & edge_mask & ~(sync ^ prev)) == '0));  // R3

  AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!srst_n)
    (((hit ^ lvl_expect) & lvl_mask) == '0));  // R6

  AST_IRQ_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!srst_n)
    (addr == ADDR_W'(FLAG_OFS)) |-> (irq == (rdata != '0)));  // R10

endmodule

bind pin_irq_detect pid_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .srst_n (srst_n),
  .code   (code_q),
  .sync   (pin_sync),
  .prev   (pin_prev),
  .hit    (pin_hit),
  .clr    (clr_mask),
  .flags  (flag_q),
  .irq    (irq_o),
  .addr   (bus_addr),
  .rdata  (bus_rdata)
);

// File: tb/tb_pin_irq_detect.sv
module tb_pin_irq_detect;

  localparam int NPINS = 32;
  localparam logic [7:0] FLAGS = 8'hA0;
  localparam logic [3:0] C_OFF = 4'h0, C_LO = 4'h8, C_RISE = 4'h9,
                         C_FALL = 4'hA, C_BOTH = 4'hB, C_HI = 4'hC;

  logic        clk;
  logic        rst_n;
  logic [31:0] pins_i;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks;
  int fails;
  bit done;

  pin_irq_detect dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins_i),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_code(int pin, logic [3:0] c);
    wr(8'(pin * 4), {12'h000, c, 16'h0000});
  endtask

  task automatic chk_flags(string req, logic [31:0] exp);
    logic [31:0] v;
    rd(FLAGS, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk_flags("R1 flags", 32'h0);
    rd(8'h14, v);
    chk("R1 code", v, 32'h0);
  endtask

  task automatic t_cfg_map;
    logic [31:0] v;
    wr(8'h0C, 32'hFFF9FFFF);
    rd(8'h0C, v);
    chk("R2 readback", v, 32'h00090000);
    rd(8'h10, v);
    chk("R2 neighbour", v, 32'h0);
    set_code(3, C_OFF);
  endtask

  task automatic t_rise;
    set_code(1, C_RISE);
    pins_i[1] = 1'b1;
    tick(2);
    chk_flags("R3 not before third edge", 32'h0);
    tick(1);
    chk_flags("R3 rising sets", 32'h2);
    chk("R10 irq high", {31'b0, irq_o}, 32'h1);
    wr(FLAGS, 32'hFFFFFFFF);
    pins_i[1] = 1'b0;
    tick(4);
    chk_flags("R3 falling ignored", 32'h0);
    chk("R10 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_fall;
    set_code(2, C_FALL);
    pins_i[2] = 1'b1;
    tick(4);
    chk_flags("R4 rising ignored", 32'h0);
    pins_i[2] = 1'b0;
    tick(3);
    chk_flags("R4 falling sets", 32'h4);
    wr(FLAGS, 32'h4);
    chk_flags("R4 cleared", 32'h0);
  endtask

  task automatic t_both;
    set_code(4, C_BOTH);
    pins_i[4] = 1'b1;
    tick(3);
    chk_flags("R5 rise", 32'h10);
    wr(FLAGS, 32'h10);
    pins_i[4] = 1'b0;
    tick(3);
    chk_flags("R5 fall", 32'h10);
    wr(FLAGS, 32'h10);
    chk_flags("R5 cleared", 32'h0);
  endtask

  task automatic t_lvl_lo;
    set_code(5, C_LO);
    tick(3);
    chk_flags("R6 low level", 32'h20);
    wr(FLAGS, 32'h20);
    chk_flags("R6 clear while low", 32'h20);
    pins_i[5] = 1'b1;
    tick(3);
    wr(FLAGS, 32'h20);
    chk_flags("R6 clear after release", 32'h0);
    set_code(5, C_OFF);
  endtask

  task automatic t_lvl_hi;
    set_code(6, C_HI);
    pins_i[6] = 1'b1;
    tick(3);
    chk_flags("R7 high level", 32'h40);
    wr(FLAGS, 32'h40);
    chk_flags("R7 clear while high", 32'h40);
    set_code(6, C_OFF);
    wr(FLAGS, 32'h40);
    tick(3);
    chk_flags("R8 disabled by zero write", 32'h0);
  endtask

  task automatic t_unlisted;
    set_code(7, 4'h3);
    pins_i[7] = 1'b1;
    tick(4);
    pins_i[7] = 1'b0;
    tick(4);
    set_code(7, 4'hF);
    tick(4);
    pins_i[7] = 1'b1;
    tick(4);
    set_code(7, C_OFF);
    pins_i[7] = 1'b0;
    tick(4);
    chk_flags("R8 unlisted and off codes", 32'h0);
    chk("R8 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_w1c;
    pins_i[1] = 1'b1;
    pins_i[4] = 1'b1;
    tick(3);
    chk_flags("R9 two flags", 32'h12);
    wr(FLAGS, 32'h0);
    chk_flags("R9 zero write", 32'h12);
    wr(FLAGS, 32'h2);
    chk_flags("R9 single clear", 32'h10);
    chk("R10 one flag", {31'b0, irq_o}, 32'h1);
    wr(FLAGS, 32'hFFFFFFFF);
    chk_flags("R9 clear all", 32'h0);
    chk("R10 no flag", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_collide;
    pins_i[4] = 1'b0;
    tick(2);
    wr(FLAGS, 32'h10);
    chk_flags("R9 event beats clear", 32'h10);
    wr(FLAGS, 32'h10);
    chk_flags("R9 clear after collision", 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    pins_i[1] = 1'b0;
    pins_i[4] = 1'b1;
    tick(3);
    chk_flags("R11 setup", 32'h10);
    wr(8'h80, 32'hFFFFFFFF);
    wr(8'h05, 32'h000F0000);
    wr(8'hA4, 32'hFFFFFFFF);
    rd(8'h04, v);
    chk("R11 code kept", v, {12'h000, C_RISE, 16'h0000});
    rd(8'h80, v);
    chk("R11 unmapped reads zero", v, 32'h0);
    chk_flags("R11 flags kept", 32'h10);
    wr(FLAGS, 32'hFFFFFFFF);
  endtask

  initial begin
    checks    = 0;
    fails     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    pins_i    = '0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_cfg_map();
    t_rise();
    t_fall();
    t_both();
    t_lvl_lo();
    t_lvl_hi();
    t_unlisted();
    t_w1c();
    t_collide();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule